// File: doc/BRIEF.md
# Address Window Decoder with Remap

This block steers a 32-bit address to one of several targets through a set of eight programmable address windows. Each window holds four 32-bit registers: a control word, a base address, a low remap address and a high remap word. The control word enables the window and gives it a target ID, an attribute byte and a size mask. The size mask is a run of ones filled upward from the least significant bit. Each one doubles the window, starting from a 64 KB granule.

An incoming address is compared against every enabled window. The address bits covered by the size mask are don't-care in the compare. The lowest-numbered matching window wins. Its target and attribute are presented with a hit flag, together with a translated address. On windows built with remap support, the translated address takes its upper bits from the remap-low register wherever the size mask is zero. On the other windows the address goes through unchanged. The high remap word is only stored and read back.

Software programs the windows through a simple write/read port, where a 5-bit index selects window and register. Lookup results and read data are both registered.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every register reads as zero, so every window is disabled and every lookup misses.
- R2: With `cfg_we` high at a clock edge, `cfg_wdata` is stored in the register chosen by `cfg_idx`. Index bits [4:2] pick the window and bits [1:0] pick the register: 0 control, 1 base, 2 remap-low, 3 remap-high. `cfg_rdata` shows, one cycle after an index is presented, the full 32-bit value last written to that register.
- R3: The control word layout is: bit 0 enable, bits [7:4] target ID, bits [15:8] attribute, bits [31:16] size mask.
- R4: A window whose enable bit is 0 never produces a hit, whatever its base and size.
- R5: A window matches when address bits [31:16] equal base bits [31:16] in every position where the size mask is 0. A mask of 0x0000 gives a 64 KB window and 0x00FF a 16 MB window.
- R6: When several enabled windows match, the lowest-numbered one supplies target, attribute and translation.
- R7: On a miss `lk_hit` is 0, `lk_target` and `lk_attr` are 0, and `lk_xaddr` equals the incoming address.
- R8: For a window with remap support (windows 0 and 1 by default), bits [31:16] of the translated address come from remap-low where the size mask is 0 and from the incoming address where it is 1. Bits [15:0] always pass through unchanged.
- R9: A window without remap support passes the address through unchanged, whatever its remap-low holds.
- R10: Setting remap-low equal to base on a remap window makes the translation the identity.
- R11: Lookup results appear on the outputs one clock edge after the address is presented, and a configuration write takes effect for addresses presented after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 5 | Window (bits 4:2) and register (bits 1:0) select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for the last index |
| lk_addr | input | 32 | Address to decode |
| lk_hit | output | 1 | A window matched |
| lk_target | output | 4 | Target ID of the winning window, 0 on miss |
| lk_attr | output | 8 | Attribute of the winning window, 0 on miss |
| lk_xaddr | output | 32 | Translated address |

## Verification
Each lookup result is due exactly one clock edge after its address is applied, and read data is due one edge after its index is applied. The bench drives every input on the falling edge and samples on the next falling edge, so the single intervening rising edge is the one that registers the result. A configuration write is stored at the rising edge inside the write task. Any lookup that relies on that write is therefore issued on a later falling edge, after the new value is in place.

// File: rtl/awd_pkg.sv
package awd_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_BASE = 2'd1,
        SEL_RMLO = 2'd2,
        SEL_RMHI = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_TGT_LSB  = 4;
    localparam int TGT_W         = 4;
    localparam int CTRL_ATTR_LSB = 8;
    localparam int ATTR_W        = 8;
    localparam int REGS_PER_WIN  = 4;

endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int DATA_W  = 32,
    localparam int WIN_W  = $clog2(NUM_WIN),
    localparam int IDX_W  = WIN_W + 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [IDX_W-1:0]               idx,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    output logic [NUM_WIN-1:0][DATA_W-1:0] ctrl_q,
    output logic [NUM_WIN-1:0][DATA_W-1:0] base_q,
    output logic [NUM_WIN-1:0][DATA_W-1:0] rmlo_q
);

    logic [DATA_W-1:0] bank [NUM_WIN][REGS_PER_WIN];
    logic [WIN_W-1:0]  win;
    reg_sel_e          sel;

    assign win = idx[IDX_W-1:2];
    assign sel = reg_sel_e'(idx[1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                for (int r = 0; r < REGS_PER_WIN; r++) begin
                    bank[w][r] <= '0;
                end
            end
        end else if (we && (int'(win) < NUM_WIN)) begin
            bank[win][sel] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (int'(win) < NUM_WIN) begin
            rdata <= bank[win][sel];
        end else begin
            rdata <= '0;
        end
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_out
        assign ctrl_q[g] = bank[g][SEL_CTRL];
        assign base_q[g] = bank[g][SEL_BASE];
        assign rmlo_q[g] = bank[g][SEL_RMLO];
    end

    // Shadow of the last write, used only by the check below.
    logic              chk_we;
    logic [WIN_W-1:0]  chk_win;
    logic [1:0]        chk_sel;
    logic [DATA_W-1:0] chk_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_we   <= 1'b0;
            chk_win  <= '0;
            chk_sel  <= '0;
            chk_data <= '0;
        end else begin
            chk_we   <= we && (int'(win) < NUM_WIN);
            chk_win  <= win;
            chk_sel  <= idx[1:0];
            chk_data <= wdata;
        end
    end

    assert_write_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_we |-> (bank[chk_win][chk_sel] == chk_data));

endmodule

// File: rtl/awd_match.sv
module awd_match
    import awd_pkg::*;
#(
    parameter int               NUM_WIN    = 8,
    parameter int               ADDR_W     = 32,
    parameter int               PAGE_W     = 16,
    parameter logic [NUM_WIN-1:0] REMAP_MASK = 8'b0000_0011,
    localparam int              HI_W       = ADDR_W - PAGE_W
) (
    input  logic [HI_W-1:0]                addr_hi,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] ctrl_q,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] base_q,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] rmlo_q,
    output logic [NUM_WIN-1:0]             hit_vec,
    output logic [NUM_WIN-1:0][HI_W-1:0]   xhi_vec
);

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic [HI_W-1:0] span;
        logic [HI_W-1:0] fixed;

        assign span  = ctrl_q[g][ADDR_W-1 -: HI_W];
        assign fixed = ~span;

        assign hit_vec[g] = ctrl_q[g][CTRL_EN_BIT] &&
                            ((addr_hi & fixed) == (base_q[g][ADDR_W-1 -: HI_W] & fixed));

        if (REMAP_MASK[g]) begin : g_remap
            assign xhi_vec[g] = (rmlo_q[g][ADDR_W-1 -: HI_W] & fixed) | (addr_hi & span);
        end else begin : g_pass
            assign xhi_vec[g] = addr_hi;
        end
    end

endmodule

// File: rtl/awd_prio.sv
module awd_prio
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int ADDR_W  = 32,
    parameter int PAGE_W  = 16,
    localparam int HI_W   = ADDR_W - PAGE_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [HI_W-1:0]                addr_hi,
    input  logic [NUM_WIN-1:0]             hit_vec,
    input  logic [NUM_WIN-1:0][HI_W-1:0]   xhi_vec,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] ctrl_q,
    output logic                           any_hit,
    output logic [TGT_W-1:0]               sel_tgt,
    output logic [ATTR_W-1:0]              sel_attr,
    output logic [HI_W-1:0]                sel_hi
);

    logic [NUM_WIN-1:0] grant;

    always_comb begin
        grant    = '0;
        any_hit  = 1'b0;
        sel_tgt  = '0;
        sel_attr = '0;
        sel_hi   = addr_hi;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (hit_vec[i] && !any_hit) begin
                any_hit  = 1'b1;
                grant[i] = 1'b1;
                sel_tgt  = ctrl_q[i][CTRL_TGT_LSB +: TGT_W];
                sel_attr = ctrl_q[i][CTRL_ATTR_LSB +: ATTR_W];
                sel_hi   = xhi_vec[i];
            end
        end
    end

    assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant != '0) == (hit_vec != '0)));

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
    import awd_pkg::*;
#(
    parameter int                 NUM_WIN    = 8,
    parameter int                 ADDR_W     = 32,
    parameter int                 PAGE_W     = 16,
    parameter logic [NUM_WIN-1:0] REMAP_MASK = 8'b0000_0011,
    localparam int                HI_W       = ADDR_W - PAGE_W,
    localparam int                IDX_W      = $clog2(NUM_WIN) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [TGT_W-1:0]  lk_target,
    output logic [ATTR_W-1:0] lk_attr,
    output logic [ADDR_W-1:0] lk_xaddr
);

    logic [NUM_WIN-1:0][ADDR_W-1:0] ctrl_q;
    logic [NUM_WIN-1:0][ADDR_W-1:0] base_q;
    logic [NUM_WIN-1:0][ADDR_W-1:0] rmlo_q;
    logic [NUM_WIN-1:0]             hit_vec;
    logic [NUM_WIN-1:0][HI_W-1:0]   xhi_vec;
    logic                           any_hit;
    logic [TGT_W-1:0]               sel_tgt;
    logic [ATTR_W-1:0]              sel_attr;
    logic [HI_W-1:0]                sel_hi;

    awd_regfile #(.NUM_WIN(NUM_WIN), .DATA_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .idx    (cfg_idx),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .ctrl_q (ctrl_q),
        .base_q (base_q),
        .rmlo_q (rmlo_q)
    );

    awd_match #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
                .REMAP_MASK(REMAP_MASK)) u_match (
        .addr_hi (lk_addr[ADDR_W-1:PAGE_W]),
        .ctrl_q  (ctrl_q),
        .base_q  (base_q),
        .rmlo_q  (rmlo_q),
        .hit_vec (hit_vec),
        .xhi_vec (xhi_vec)
    );

    awd_prio #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_prio (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_hi  (lk_addr[ADDR_W-1:PAGE_W]),
        .hit_vec  (hit_vec),
        .xhi_vec  (xhi_vec),
        .ctrl_q   (ctrl_q),
        .any_hit  (any_hit),
        .sel_tgt  (sel_tgt),
        .sel_attr (sel_attr),
        .sel_hi   (sel_hi)
    );

    // Result stage (R11)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_hit    <= 1'b0;
            lk_target <= '0;
            lk_attr   <= '0;
            lk_xaddr  <= '0;
        end else begin
            lk_hit    <= any_hit;
            lk_target <= sel_tgt;
            lk_attr   <= sel_attr;
            lk_xaddr  <= {sel_hi, lk_addr[PAGE_W-1:0]};
        end
    end

    logic primed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    assert_reset_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |-> (!lk_hit && lk_target == '0 && lk_attr == '0));

    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !lk_hit) |->
            (lk_target == '0 && lk_attr == '0 && lk_xaddr == $past(lk_addr)));

    assert_low_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (lk_xaddr[PAGE_W-1:0] == $past(lk_addr[PAGE_W-1:0])));

endmodule

// File: tb/test_addr_window_decoder.sv
module test_addr_window_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] lk_addr = '0;
    logic        lk_hit;
    logic [3:0]  lk_target;
    logic [7:0]  lk_attr;
    logic [31:0] lk_xaddr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    addr_window_decoder i_addr_window_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .lk_addr   (lk_addr),
        .lk_hit    (lk_hit),
        .lk_target (lk_target),
        .lk_attr   (lk_attr),
        .lk_xaddr  (lk_xaddr)
    );

    // {addr, hit, target, attr, translated}
    localparam logic [76:0] VECS [0:10] = '{
        {32'h9ABC_1234, 1'b1, 4'h1, 8'hE8, 32'h9ABC_1234}, // R5 R10 window 0 identity
        {32'hA000_0000, 1'b0, 4'h0, 8'h00, 32'hA000_0000}, // R7 miss
        {32'hC000_BEEF, 1'b1, 4'h1, 8'hE0, 32'hC010_BEEF}, // R8 64 KB remap window
        {32'hC001_0000, 1'b0, 4'h0, 8'h00, 32'hC001_0000}, // R5 just past 64 KB
        {32'hD8FF_FFFF, 1'b1, 4'h2, 8'h2F, 32'hD8FF_FFFF}, // R9 no-remap window
        {32'hD900_0000, 1'b0, 4'h0, 8'h00, 32'hD900_0000}, // R5 past 16 MB
        {32'hF8AB_CDEF, 1'b1, 4'h3, 8'h1E, 32'hF8AB_CDEF}, // R6 window 3 beats 4
        {32'hF900_0001, 1'b1, 4'h3, 8'h1E, 32'hF900_0001}, // R6 only window 3
        {32'h4012_3456, 1'b0, 4'h0, 8'h00, 32'h4012_3456}, // R4 disabled window
        {32'h9000_0000, 1'b1, 4'h1, 8'hE8, 32'h9000_0000}, // R5 lower edge
        {32'h9FFF_FFFF, 1'b1, 4'h1, 8'hE8, 32'h9FFF_FFFF}  // R5 upper edge
    };

    function automatic logic [4:0] ix(input int w, input int s);
        return {w[2:0], s[1:0]};
    endfunction

    task automatic wr(input int w, input int s, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_idx   = ix(w, s);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int w, input int s, input logic [31:0] exp);
        @(negedge clk);
        cfg_idx = ix(w, s);
        @(negedge clk);
        checks++;
        if (cfg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: rdata act=%h exp=%h", tag, cfg_rdata, exp);
        end
    endtask

    task automatic lk_chk(input string tag, input logic [31:0] a, input logic [44:0] exp);
        @(negedge clk);
        lk_addr = a;
        @(negedge clk);
        checks++;
        if ({lk_hit, lk_target, lk_attr, lk_xaddr} !== exp) begin
            errors++;
            $display("FAIL %s: addr=%h act=%h exp=%h", tag, a,
                     {lk_hit, lk_target, lk_attr, lk_xaddr}, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 ctrl w0", 0, 0, 32'h0);
        rd_chk("R1 base w7", 7, 1, 32'h0);
        lk_chk("R1 reset lookup", 32'h0000_0000, {1'b0, 4'h0, 8'h00, 32'h0000_0000});

        // R3 control layout: {size, attr, target, 3'b0, enable}
        wr(0, 0, 32'h0FFF_E811); wr(0, 1, 32'h9000_0000); wr(0, 2, 32'h9000_0000);
        wr(1, 0, 32'h0000_E011); wr(1, 1, 32'hC000_0000); wr(1, 2, 32'hC010_0000);
        wr(2, 0, 32'h00FF_2F21); wr(2, 1, 32'hD800_0000); wr(2, 2, 32'h1234_0000);
        wr(2, 3, 32'hDEAD_BEEF);
        wr(3, 0, 32'h07FF_1E31); wr(3, 1, 32'hF800_0000);
        wr(4, 0, 32'h00FF_0F41); wr(4, 1, 32'hF800_0000);
        wr(5, 0, 32'h00FF_5550); wr(5, 1, 32'h4000_0000);

        // R2 readback
        rd_chk("R2 remap-lo w2", 2, 2, 32'h1234_0000);
        rd_chk("R2 remap-hi w2", 2, 3, 32'hDEAD_BEEF);
        rd_chk("R2 ctrl w1", 1, 0, 32'h0000_E011);
        rd_chk("R2 base w6 untouched", 6, 1, 32'h0);

        for (int k = 0; k < 11; k++) begin
            lk_chk($sformatf("R3 R11 vector %0d", k), VECS[k][76:45], VECS[k][44:0]);
        end

        // R4: enabling window 5 makes the same address hit
        wr(5, 0, 32'h00FF_5551);
        lk_chk("R4 now enabled", 32'h4012_3456, {1'b1, 4'h5, 8'h55, 32'h4012_3456});

        // R8: partial mask, 1 MB window on remap window 1
        wr(1, 0, 32'h000F_E011);
        wr(1, 2, 32'h2350_0000);
        lk_chk("R8 partial remap", 32'hC00A_5555, {1'b1, 4'h1, 8'hE0, 32'h235A_5555});

        // R9: remap-lo on a no-remap window has no effect
        wr(2, 2, 32'hFFFF_0000);
        lk_chk("R9 no remap", 32'hD812_0001, {1'b1, 4'h2, 8'h2F, 32'hD812_0001});

        // R6: window 0 overlapping window 1 wins
        wr(0, 0, 32'hFFFF_E871);
        lk_chk("R6 lowest wins", 32'hC00A_5555, {1'b1, 4'h7, 8'hE8, 32'hC00A_5555});

        // R11: write lands at an edge, next lookup sees it
        wr(0, 0, 32'h0);
        lk_chk("R11 after disable", 32'hC00A_5555, {1'b1, 4'h1, 8'hE0, 32'h235A_5555});

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule